// File: doc/BRIEF.md
# Software Write-Lock Command Sequencer

This block sits between a host write port and the page-load controller of a byte-wide nonvolatile memory. It inspects the address and data of every accepted write. It recognises two fixed unlock patterns: a three-write arming sequence and a six-write release sequence. From these it decides which writes may reach the page controller. The command writes themselves never reach the array.

The arming sequence sets a lock flag and opens one load window. Ordinary writes pass through that window until the page controller reports that the load has closed. From then on the device stays locked until the release sequence is issued. The lock flag models a nonvolatile bit. The ordinary power-on reset does not touch it, and only a separate factory-reset input clears it. When the lock is clear, ordinary writes pass straight through without any prefix.

Top module: `wp_cmd_seq`

## Requirements
- R1: After power-on and factory reset are both applied, the lock flag reads 0, the window flag reads 0 and no write is presented downstream.
- R2: With the lock clear and no sequence in progress, a write of any other pattern appears on the pass outputs one clock later with its address and data unchanged.
- R3: The arming sequence is three writes: data 0xAA to key address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Completing it sets the lock flag and opens the load window.
- R4: A write consumed as a step of either sequence is never presented downstream, whether or not the lock is set.
- R5: While the window is open, every write passes downstream, including writes that look like command steps, and no sequence is matched. A one-cycle pulse on `load_done` closes the window.
- R6: With the lock set and the window closed, every write that is not a sequence step is dropped.
- R7: A write that breaks a partly matched sequence returns the matcher to its first step. That write is then handled as an ordinary write (dropped when locked, passed when unlocked), and a complete sequence issued afterwards is still recognised.
- R8: Power-on reset (`rst_n` low) clears the window and the matcher but leaves the lock flag unchanged.
- R9: Only address bits 14..0 are compared with the key addresses; bit 15 is ignored.
- R10: The release sequence is six writes: 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555. Completing it clears the lock flag, after which ordinary writes pass.
- R11: Factory reset (`factory_rst_n` low) clears the lock flag and the window.
- R12: A `load_done` pulse while the window is closed has no effect on the lock flag or on the dropping of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; leaves the lock flag unchanged |
| factory_rst_n | input | 1 | Synchronous active-low factory reset; clears everything including the lock |
| wr_valid | input | 1 | Qualified host write strobe, one cycle per write |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| load_done | input | 1 | Page controller pulse: the load window has closed |
| pass_valid | output | 1 | Write forwarded to the page controller |
| pass_addr | output | 16 | Forwarded address |
| pass_data | output | 8 | Forwarded data |
| locked | output | 1 | Lock flag (models the nonvolatile protection bit) |
| window_open | output | 1 | Single page-load window is open |

## Verification
The bench targets the places where a sequencer most often fails. A broken sequence must be handled correctly: a design that does not restart the matcher would ignore a later valid sequence, and one that drops the breaking write while unlocked would lose user data. Command-like writes inside an open window must pass; a design that keeps matching there would swallow page data. Key addresses with bit 15 set must still match; a design that compares all 16 bits would not recognise them. After a power-on reset the lock must survive; a design that resets it there would open the array, and one that keeps the window open after the reset would let stray writes through.

// File: rtl/wp_cmd_pkg.sv
// Package: constants and step encoding shared by the write-lock sequencer.
// Assumes a 16-bit address whose low 15 bits carry the key addresses.
package wp_cmd_pkg;
    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  KEY_OPEN   = 8'hAA;
    localparam logic [7:0]  KEY_CONF   = 8'h55;
    localparam logic [7:0]  KEY_ARM    = 8'hA0;
    localparam logic [7:0]  KEY_EXT    = 8'h80;
    localparam logic [7:0]  KEY_FREE   = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GOT1  = 3'd1,
        ST_GOT2  = 3'd2,
        ST_GOT3  = 3'd3,
        ST_GOT4  = 3'd4,
        ST_GOT5  = 3'd5
    } step_e;
endpackage

// File: rtl/wp_seq_match.sv
// Module: combinational pattern matcher for the arming and release sequences.
// Given the current step and one write, it says whether the write is a
// sequence step, the next step, and whether a sequence just completed.
// Assumes the caller only commits step_nxt when a write is accepted.
module wp_seq_match
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  step_e             step,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output logic              arm,
    output logic              release_done,
    output step_e             step_nxt
);
    localparam int KEY_W = 15;

    logic at_a;
    logic at_b;

    // Compare only the key bits; upper address bits are don't-care.
    always_comb begin
        at_a = (addr[KEY_W-1:0] == KEY_ADDR_A);
        at_b = (addr[KEY_W-1:0] == KEY_ADDR_B);
    end

    // Step decoder: advance on a match, otherwise fall back to the first step.
    always_comb begin
        hit          = 1'b0;
        arm          = 1'b0;
        release_done = 1'b0;
        step_nxt     = ST_IDLE;
        if (en) begin
            case (step)
                ST_IDLE: if (at_a && data == KEY_OPEN) begin hit = 1'b1; step_nxt = ST_GOT1; end
                ST_GOT1: if (at_b && data == KEY_CONF) begin hit = 1'b1; step_nxt = ST_GOT2; end
                ST_GOT2: begin
                    if (at_a && data == KEY_ARM) begin
                        hit = 1'b1;
                        arm = 1'b1;
                    end else if (at_a && data == KEY_EXT) begin
                        hit      = 1'b1;
                        step_nxt = ST_GOT3;
                    end
                end
                ST_GOT3: if (at_a && data == KEY_OPEN) begin hit = 1'b1; step_nxt = ST_GOT4; end
                ST_GOT4: if (at_b && data == KEY_CONF) begin hit = 1'b1; step_nxt = ST_GOT5; end
                ST_GOT5: if (at_a && data == KEY_FREE) begin hit = 1'b1; release_done = 1'b1; end
                default: step_nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wp_persist_flag.sv
// Module: the lock flag, standing in for a nonvolatile bit.
// Only factory reset clears it. A release request wins over an arm request.
// Assumes set and clr are single-cycle qualified pulses.
module wp_persist_flag (
    input  logic clk,
    input  logic factory_rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold state; change only on an explicit command or factory reset.
    always_ff @(posedge clk) begin
        if (!factory_rst_n)  q <= 1'b0;
        else if (clr)        q <= 1'b0;
        else if (set)        q <= 1'b1;
    end

    AST_FLAG_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!factory_rst_n)
        (q && !clr) |=> q); // R8
    AST_FLAG_HOLDS_LOW: assert property (@(posedge clk) disable iff (!factory_rst_n)
        (!q && !set) |=> !q); // R12
endmodule

// File: rtl/wp_cmd_seq.sv
// Module: write-lock command sequencer (top).
// Watches each accepted write, steps the sequence matcher, keeps the lock
// flag and the single load window, and forwards permitted writes one cycle
// later. Assumes load_done comes from the page controller once per load.
module wp_cmd_seq
    import wp_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              factory_rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_done,
    output logic              pass_valid,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [DATA_W-1:0] pass_data,
    output logic              locked,
    output logic              window_open
);
    step_e step_q;
    step_e step_nxt;
    logic  cmd_hit;
    logic  cmd_arm;
    logic  cmd_release;
    logic  win_q;
    logic  sys_rst;
    logic  permit;

    assign sys_rst = !rst_n || !factory_rst_n;

    wp_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .en           (!win_q),
        .step         (step_q),
        .addr         (wr_addr),
        .data         (wr_data),
        .hit          (cmd_hit),
        .arm          (cmd_arm),
        .release_done (cmd_release),
        .step_nxt     (step_nxt)
    );

    wp_persist_flag u_flag (
        .clk           (clk),
        .factory_rst_n (factory_rst_n),
        .set           (wr_valid && cmd_arm),
        .clr           (wr_valid && cmd_release),
        .q             (locked)
    );

    // Matcher step register: commit the next step on each accepted write.
    always_ff @(posedge clk) begin
        if (sys_rst)       step_q <= ST_IDLE;
        else if (wr_valid) step_q <= step_nxt;
    end

    // Load window: opened by the arming sequence, closed by the controller.
    always_ff @(posedge clk) begin
        if (sys_rst)                   win_q <= 1'b0;
        else if (wr_valid && cmd_arm)  win_q <= 1'b1;
        else if (load_done)            win_q <= 1'b0;
    end

    // A write may go downstream when unlocked or inside the window.
    always_comb permit = wr_valid && !cmd_hit && (!locked || win_q);

    // Output stage: register the forwarded write.
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            pass_valid <= 1'b0;
            pass_addr  <= '0;
            pass_data  <= '0;
        end else begin
            pass_valid <= permit;
            if (permit) begin
                pass_addr <= wr_addr;
                pass_data <= wr_data;
            end
        end
    end

    assign window_open = win_q;

    AST_CMD_NEVER_FORWARDED: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_valid && cmd_hit) |=> !pass_valid); // R4
    AST_WINDOW_FORWARDS: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_valid && win_q) |=> pass_valid); // R5
    AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (sys_rst)
        (wr_valid && locked && !win_q) |=> !pass_valid); // R6
    AST_WINDOW_NEEDS_LOCK: assert property (@(posedge clk) disable iff (sys_rst)
        win_q |-> locked); // R3
    AST_OUTPUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (sys_rst)
        pass_valid |-> $past(wr_valid)); // R2
endmodule

// File: tb/wp_cmd_seq_test.sv
// Scoreboard bench: the driver queues expected forwarded writes; a monitor
// pops and compares each one the design presents.
module wp_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        factory_rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_done = 1'b0;
    logic        pass_valid;
    logic [15:0] pass_addr;
    logic [7:0]  pass_data;
    logic        locked;
    logic        window_open;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    typedef struct packed { logic [15:0] a; logic [7:0] d; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    wp_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_done(load_done), .pass_valid(pass_valid), .pass_addr(pass_addr),
        .pass_data(pass_data), .locked(locked), .window_open(window_open)
    );

    // Monitor: compare every forwarded write against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && factory_rst_n && pass_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: forwarded addr=%h data=%h, expected no write", cur_req, pass_addr, pass_data);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (e.a !== pass_addr || e.d !== pass_data) begin
                    fails++;
                    $display("FAIL %s: forwarded addr=%h data=%h, expected addr=%h data=%h",
                             cur_req, pass_addr, pass_data, e.a, e.d);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit fwd);
        if (fwd) exp_q.push_back('{a: a, d: d});
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drained(input string req);
        #1;
        chk(req, "pending expected writes", exp_q.size(), 0);
    endtask

    task automatic pulse_done();
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
    endtask

    task automatic arm_seq(input logic [15:0] hi);
        wr(16'h5555 | hi, 8'hAA, 0);
        wr(16'h2AAA | hi, 8'h55, 0);
        wr(16'h5555, 8'hA0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; factory_rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "locked after reset", locked, 0);
        chk("R1", "window after reset", window_open, 0);
        chk("R1", "pass_valid after reset", pass_valid, 0);

        cur_req = "R2";
        wr(16'h1234, 8'h5A, 1);
        wr(16'hF00F, 8'hC3, 1);
        drained("R2");

        cur_req = "R4";
        arm_seq(16'h0000);
        drained("R4");
        chk("R3", "locked after arming", locked, 1);
        chk("R3", "window after arming", window_open, 1);

        cur_req = "R5";
        wr(16'h0100, 8'h11, 1);
        wr(16'h5555, 8'hAA, 1);
        wr(16'h2AAA, 8'h55, 1);
        wr(16'h5555, 8'h20, 1);
        drained("R5");
        chk("R5", "locked during window", locked, 1);
        pulse_done();
        chk("R5", "window after load_done", window_open, 0);

        cur_req = "R6";
        wr(16'h0200, 8'h22, 0);
        drained("R6");
        chk("R6", "locked after load", locked, 1);

        cur_req = "R12";
        pulse_done();
        chk("R12", "locked after stray load_done", locked, 1);
        wr(16'h0210, 8'h23, 0);
        drained("R12");

        cur_req = "R8";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8", "locked after power-on reset", locked, 1);
        wr(16'h0220, 8'h24, 0);
        drained("R8");

        cur_req = "R7";
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h55, 0);
        wr(16'h1000, 8'h33, 0);
        wr(16'h5555, 8'hA0, 0);
        drained("R7");
        chk("R7", "window after broken sequence", window_open, 0);
        arm_seq(16'h0000);
        chk("R7", "window after fresh sequence", window_open, 1);
        pulse_done();

        cur_req = "R9";
        arm_seq(16'h8000);
        chk("R9", "window with bit15 set", window_open, 1);
        wr(16'h0300, 8'h44, 1);
        drained("R9");
        pulse_done();

        cur_req = "R10";
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h55, 0);
        wr(16'h5555, 8'h80, 0);
        wr(16'h5555, 8'hAA, 0);
        wr(16'h2AAA, 8'h55, 0);
        wr(16'h5555, 8'h20, 0);
        drained("R10");
        chk("R10", "locked after release", locked, 0);
        wr(16'h0400, 8'h55, 1);
        drained("R10");

        cur_req = "R7";
        wr(16'h5555, 8'hAA, 0);
        wr(16'h4000, 8'h77, 1);
        drained("R7");
        chk("R7", "locked after unlocked break", locked, 0);

        cur_req = "R11";
        arm_seq(16'h0000);
        chk("R11", "locked before factory reset", locked, 1);
        @(negedge clk); factory_rst_n = 1'b0;
        @(negedge clk); factory_rst_n = 1'b1;
        chk("R11", "locked after factory reset", locked, 0);
        chk("R11", "window after factory reset", window_open, 0);
        wr(16'h0500, 8'h66, 1);
        drained("R11");

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule